// File: doc/BRIEF.md
# JTAG Test Data Path (Instruction, Bypass and Identification Registers)

This block is the serial data path that sits behind a JTAG TAP state machine. The controller tells it, once per rising TCK edge, whether it is in a capture, shift or update state, whether the instruction chain is the one addressed, and whether it is in Test-Logic-Reset. The block holds an instruction register made of a shift stage and a hold stage. It also holds a one-bit bypass register and a 32-bit identification register. It drives the serial output from whichever chain is currently addressed.

The instruction in the hold stage is decoded into one of three data-path selections. The all-ones opcode, and every opcode the block does not recognise, selects bypass. The identification opcode selects the ID register. The all-zeros opcode selects the external boundary-scan chain, whose serial return comes in on its own input. The boundary cells themselves live outside this block. Every strobe is sampled on the rising TCK edge. The serial output is taken straight from register bits, with no extra pipeline stage.

Top module: `tap_data_path`

## Requirements
- R1: After the asynchronous reset, and on the rising edge after a cycle with `tlr_i` high, the active instruction becomes the identification opcode (binary 0010 with the default 4-bit register), or all ones when no ID register is configured. `tlr_i` takes priority over an update in the same cycle.
- R2: In a cycle with `sel_ir_i` and `capture_i` high, the instruction shift stage loads binary 01 into bits [1:0] and `ir_status_i` into bits [IR_W-1:2].
- R3: While `sel_ir_i` is high, `tdo_o` is bit 0 of the instruction shift stage. Each shift cycle moves the stage one place toward bit 0, with `tdi_i` entering at the top bit, so the captured value leaves least significant bit first.
- R4: The active instruction `active_ir_o` takes the shift-stage value only on an edge that ends a cycle with `sel_ir_i` and `update_i` high, or on reset. It holds its value through capture and shift.
- R5: With the all-ones opcode active, a data-register capture loads 0 into the bypass register. Data-register shifting then delays `tdi_i` by exactly one TCK cycle on the way to `tdo_o`.
- R6: A data-register update leaves the bypass register untouched, so `tdo_o` and `active_ir_o` do not change across it.
- R7: With the identification opcode active, a data-register capture loads the 32-bit constant `ID_VALUE`. That value then appears on `tdo_o` least significant bit first, followed by the bits entered on `tdi_i`.
- R8: With the all-zeros opcode active, `bsr_sel_o` is high. While `sel_ir_i` is low, `tdo_o` follows `bsr_tdo_i` in the same cycle.
- R9: Any opcode other than all zeros, all ones or the identification opcode behaves exactly as bypass, with `bsr_sel_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; all registers use its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial test data in |
| tlr_i | input | 1 | Controller is in Test-Logic-Reset |
| sel_ir_i | input | 1 | Controller is in an instruction-register state |
| capture_i | input | 1 | Controller is in a capture state |
| shift_i | input | 1 | Controller is in a shift state |
| update_i | input | 1 | Controller is in an update state |
| ir_status_i | input | IR_W-2 (min 1) | Status bits captured into the upper instruction bits |
| bsr_tdo_i | input | 1 | Serial return of the external boundary-scan chain |
| tdo_o | output | 1 | Serial test data out source |
| active_ir_o | output | IR_W | Instruction in the hold stage |
| bsr_sel_o | output | 1 | External-test chain is the selected data path |

## Verification
The hardest state to reach from the ports is a data-register scan that runs past the end of the selected register. In that case the output must switch from captured content to the one-cycle or 32-cycle delayed copy of the input. The scan must also directly follow an instruction update that changed the selection. The random stimulus chains an instruction scan with a random or special opcode directly into a data scan of random length from 1 to 48 bits. The bench predicts every output bit from the opcode, the length and the input bits. Directed cases cover a reset strobe arriving while the external test is active, an update with the bypass register holding a one, and a check that the hold stage does not change partway through an instruction shift.

// File: rtl/tdp_pkg.sv
`timescale 1ns/1ps
package tdp_pkg;

    // Data-path selection derived from the active instruction
    typedef enum logic [1:0] {
        KIND_BYPASS = 2'd0,
        KIND_IDCODE = 2'd1,
        KIND_EXTEST = 2'd2
    } dr_kind_e;

    localparam int unsigned ID_W = 32;

endpackage

// File: rtl/tdp_ir_stage.sv
`timescale 1ns/1ps
module tdp_ir_stage #(
    parameter int unsigned     IR_W     = 4,
    parameter logic [IR_W-1:0] RESET_OP = '1,
    localparam int unsigned    ST_W     = (IR_W > 2) ? IR_W - 2 : 1
) (
    input  logic            tck_i,
    input  logic            rst_ni,
    input  logic            tlr_i,
    input  logic            sel_ir_i,
    input  logic            capture_i,
    input  logic            shift_i,
    input  logic            update_i,
    input  logic            tdi_i,
    input  logic [ST_W-1:0] status_i,
    output logic            sh_lsb_o,
    output logic [IR_W-1:0] hold_o
);

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] hold;
    } ir_state_t;

    ir_state_t       st_d, st_q;
    logic [IR_W-1:0] cap_val;

    // Capture pattern: fixed 01 at the bottom, status above it
    generate
        if (IR_W > 2) begin : g_status
            assign cap_val = {status_i, 2'b01};
        end else begin : g_bare
            logic unused_status;
            assign unused_status = ^status_i;
            assign cap_val       = 2'b01;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (sel_ir_i && capture_i) begin
            st_d.sh = cap_val;
        end else if (sel_ir_i && shift_i) begin
            st_d.sh = {tdi_i, st_q.sh[IR_W-1:1]};
        end
        if (tlr_i) begin
            st_d.hold = RESET_OP;
        end else if (sel_ir_i && update_i) begin
            st_d.hold = st_q.sh;
        end
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sh   <= '0;
            st_q.hold <= RESET_OP;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_lsb_o = st_q.sh[0];
    assign hold_o   = st_q.hold;

endmodule

// File: rtl/tdp_decode.sv
`timescale 1ns/1ps
module tdp_decode
    import tdp_pkg::*;
#(
    parameter int unsigned     IR_W      = 4,
    parameter logic [IR_W-1:0] IDCODE_OP = IR_W'(2),
    parameter bit              HAS_ID    = 1'b1
) (
    input  logic [IR_W-1:0] instr_i,
    output dr_kind_e        kind_o
);

    always_comb begin
        if (instr_i == '0) begin
            kind_o = KIND_EXTEST;
        end else if (HAS_ID && (instr_i == IDCODE_OP)) begin
            kind_o = KIND_IDCODE;
        end else begin
            // all ones and every unknown opcode
            kind_o = KIND_BYPASS;
        end
    end

endmodule

// File: rtl/tdp_dr_stage.sv
`timescale 1ns/1ps
module tdp_dr_stage
    import tdp_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_E0F3,
    parameter bit              HAS_ID   = 1'b1
) (
    input  logic     tck_i,
    input  logic     rst_ni,
    input  logic     sel_ir_i,
    input  logic     capture_i,
    input  logic     shift_i,
    input  logic     tdi_i,
    input  dr_kind_e kind_i,
    output logic     byp_o,
    output logic     id_lsb_o
);

    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_state_t;

    dr_state_t st_d, st_q;
    logic      dr_cap, dr_shf;

    assign dr_cap = !sel_ir_i && capture_i;
    assign dr_shf = !sel_ir_i && shift_i && !capture_i;

    always_comb begin
        st_d = st_q;
        unique case (kind_i)
            KIND_BYPASS: begin
                if (dr_cap)      st_d.byp = 1'b0;
                else if (dr_shf) st_d.byp = tdi_i;
            end
            KIND_IDCODE: begin
                if (dr_cap)      st_d.id = ID_VALUE;
                else if (dr_shf) st_d.id = {tdi_i, st_q.id[ID_W-1:1]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byp_o = st_q.byp;

    generate
        if (HAS_ID) begin : g_id
            assign id_lsb_o = st_q.id[0];
        end else begin : g_no_id
            assign id_lsb_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/tap_data_path.sv
`timescale 1ns/1ps
module tap_data_path
    import tdp_pkg::*;
#(
    parameter int unsigned     IR_W      = 4,
    parameter bit              HAS_ID    = 1'b1,
    parameter logic [IR_W-1:0] IDCODE_OP = IR_W'(2),
    parameter logic [ID_W-1:0] ID_VALUE  = 32'h1A5C_E0F3,
    localparam int unsigned    ST_W      = (IR_W > 2) ? IR_W - 2 : 1,
    localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? IDCODE_OP : {IR_W{1'b1}}
) (
    input  logic            tck_i,
    input  logic            rst_ni,
    input  logic            tdi_i,
    input  logic            tlr_i,
    input  logic            sel_ir_i,
    input  logic            capture_i,
    input  logic            shift_i,
    input  logic            update_i,
    input  logic [ST_W-1:0] ir_status_i,
    input  logic            bsr_tdo_i,
    output logic            tdo_o,
    output logic [IR_W-1:0] active_ir_o,
    output logic            bsr_sel_o
);

    logic     ir_lsb, byp_bit, id_bit;
    dr_kind_e kind;

    tdp_ir_stage #(
        .IR_W     (IR_W),
        .RESET_OP (RESET_OP)
    ) u_ir (
        .tck_i     (tck_i),
        .rst_ni    (rst_ni),
        .tlr_i     (tlr_i),
        .sel_ir_i  (sel_ir_i),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .tdi_i     (tdi_i),
        .status_i  (ir_status_i),
        .sh_lsb_o  (ir_lsb),
        .hold_o    (active_ir_o)
    );

    tdp_decode #(
        .IR_W      (IR_W),
        .IDCODE_OP (IDCODE_OP),
        .HAS_ID    (HAS_ID)
    ) u_dec (
        .instr_i (active_ir_o),
        .kind_o  (kind)
    );

    tdp_dr_stage #(
        .ID_VALUE (ID_VALUE),
        .HAS_ID   (HAS_ID)
    ) u_dr (
        .tck_i     (tck_i),
        .rst_ni    (rst_ni),
        .sel_ir_i  (sel_ir_i),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .tdi_i     (tdi_i),
        .kind_i    (kind),
        .byp_o     (byp_bit),
        .id_lsb_o  (id_bit)
    );

    // Serial output select
    always_comb begin
        if (sel_ir_i) begin
            tdo_o = ir_lsb;
        end else begin
            unique case (kind)
                KIND_IDCODE: tdo_o = id_bit;
                KIND_EXTEST: tdo_o = bsr_tdo_i;
                default:     tdo_o = byp_bit;
            endcase
        end
    end

    assign bsr_sel_o = (kind == KIND_EXTEST);

endmodule

// File: rtl/tdp_checker.sv
`timescale 1ns/1ps
module tdp_checker #(
    parameter int unsigned     IR_W     = 4,
    parameter logic [IR_W-1:0] RESET_OP = '1
) (
    input logic            tck_i,
    input logic            rst_ni,
    input logic            tlr_i,
    input logic            sel_ir_i,
    input logic            capture_i,
    input logic            update_i,
    input logic            bsr_tdo_i,
    input logic            tdo_o,
    input logic [IR_W-1:0] active_ir_o,
    input logic            bsr_sel_o
);

    p_tlr_load_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
        tlr_i |=> (active_ir_o == RESET_OP));

    p_ir_capture_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (sel_ir_i && capture_i) |=> (!sel_ir_i || tdo_o == 1'b1));

    p_hold_stable_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (!tlr_i && !(sel_ir_i && update_i)) |=> $stable(active_ir_o));

    p_bypass_capture_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (!sel_ir_i && capture_i && !tlr_i && active_ir_o == '1)
            |=> (sel_ir_i || tdo_o == 1'b0));

    p_extest_route_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
        (bsr_sel_o && !sel_ir_i) |-> (tdo_o == bsr_tdo_i));

    p_extest_only_zero_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
        bsr_sel_o |-> (active_ir_o == '0));

endmodule

bind tap_data_path tdp_checker #(
    .IR_W     (IR_W),
    .RESET_OP (RESET_OP)
) u_chk (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .tlr_i       (tlr_i),
    .sel_ir_i    (sel_ir_i),
    .capture_i   (capture_i),
    .update_i    (update_i),
    .bsr_tdo_i   (bsr_tdo_i),
    .tdo_o       (tdo_o),
    .active_ir_o (active_ir_o),
    .bsr_sel_o   (bsr_sel_o)
);

// File: tb/tap_data_path_bench.sv
`timescale 1ns/1ps
module tap_data_path_bench;

    localparam logic [31:0] IDV   = 32'h1A5C_E0F3;
    localparam logic [3:0]  OP_ID = 4'b0010;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdi = 1'b0, tlr = 1'b0, sel_ir = 1'b0;
    logic       cap = 1'b0, shf = 1'b0, upd = 1'b0;
    logic [1:0] status = 2'b00;
    logic       bsr = 1'b0;
    logic       tdo;
    logic [3:0] air;
    logic       bsel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 tck = ~tck;

    tap_data_path #(
        .IR_W(4), .HAS_ID(1'b1), .IDCODE_OP(OP_ID), .ID_VALUE(IDV)
    ) u_tap_data_path (
        .tck_i(tck), .rst_ni(rst_n), .tdi_i(tdi), .tlr_i(tlr),
        .sel_ir_i(sel_ir), .capture_i(cap), .shift_i(shf), .update_i(upd),
        .ir_status_i(status), .bsr_tdo_i(bsr), .tdo_o(tdo),
        .active_ir_o(air), .bsr_sel_o(bsel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Expected serial output of a data scan
    function automatic logic [63:0] exp_dr(input logic [3:0] op, input int n,
                                           input logic [63:0] din, input logic [63:0] bp);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) begin
            if (op == 4'b0000)      r[i] = bp[i];
            else if (op == OP_ID)   r[i] = (i < 32) ? IDV[i] : din[i-32];
            else                    r[i] = (i == 0) ? 1'b0 : din[i-1];
        end
        return r;
    endfunction

    // R2 R3 R4: instruction scan
    task automatic ir_scan(input logic [3:0] din, input logic [1:0] st);
        logic [3:0] dout;
        logic [3:0] prev;
        prev = air;
        @(negedge tck); sel_ir = 1'b1; cap = 1'b1; status = st;
        for (int i = 0; i < 4; i++) begin
            @(negedge tck); cap = 1'b0; shf = 1'b1; tdi = din[i];
            #2 dout[i] = tdo;
        end
        @(negedge tck); shf = 1'b0; upd = 1'b1;
        #2 check("R4 hold before update", 64'(air), 64'(prev));
        @(negedge tck); upd = 1'b0; sel_ir = 1'b0;
        #2 check("R4 hold after update", 64'(air), 64'(din));
        check("R2 R3 captured ir", 64'(dout), 64'({st, 2'b01}));
    endtask

    task automatic dr_scan(input int n, input logic [63:0] din, input logic [63:0] bp,
                           output logic [63:0] dout);
        dout = '0;
        @(negedge tck); sel_ir = 1'b0; cap = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge tck); cap = 1'b0; shf = 1'b1; tdi = din[i]; bsr = bp[i];
            #2 dout[i] = tdo;
        end
        @(negedge tck); shf = 1'b0; upd = 1'b1;
        @(negedge tck); upd = 1'b0;
    endtask

    initial begin
        logic [63:0] din, bp, dout;
        logic [3:0]  op;
        int          n;
        logic        t1, t2;
        void'($urandom(32'd1234));

        #25; // reset state
        check("R1 reset opcode", 64'(air), 64'(OP_ID));
        check("R8 reset bsr_sel low", 64'(bsel), 64'd0);
        rst_n = 1'b1;

        // R7 directed: identification read with 40 bits
        din = {$urandom, $urandom};
        dr_scan(40, din, 64'd0, dout);
        check("R7 idcode read", dout, exp_dr(OP_ID, 40, din, 0));

        // R8 directed: external test, then R1 strobe
        ir_scan(4'b0000, 2'b10);
        check("R8 bsr_sel high", 64'(bsel), 64'd1);
        bp = {$urandom, $urandom}; din = {$urandom, $urandom};
        dr_scan(20, din, bp, dout);
        check("R8 extest route", dout, exp_dr(4'b0000, 20, din, bp));
        @(negedge tck); tlr = 1'b1; upd = 1'b1; sel_ir = 1'b1;
        @(negedge tck); tlr = 1'b0; upd = 1'b0; sel_ir = 1'b0;
        #2 check("R1 tlr opcode", 64'(air), 64'(OP_ID));
        check("R1 tlr bsr_sel", 64'(bsel), 64'd0);

        // R5 R6 directed: bypass capture and update
        ir_scan(4'b1111, 2'b01);
        @(negedge tck); cap = 1'b1;
        @(negedge tck); cap = 1'b0; shf = 1'b1; tdi = 1'b1;
        #2 check("R5 bypass captured zero", 64'(tdo), 64'd0);
        @(negedge tck); shf = 1'b0; upd = 1'b1;
        #2 t1 = tdo;
        @(negedge tck); upd = 1'b0;
        #2 t2 = tdo;
        check("R6 tdo in update", 64'(t1), 64'd1);
        check("R6 tdo after update", 64'(t2), 64'd1);
        check("R6 opcode kept", 64'(air), 64'hF);

        // R9 directed: unknown opcode
        ir_scan(4'b0101, 2'b11);
        check("R9 bsr_sel low", 64'(bsel), 64'd0);
        din = {$urandom, $urandom};
        dr_scan(9, din, '1, dout);
        check("R9 acts as bypass", dout, exp_dr(4'b0101, 9, din, '1));

        // Random mix
        for (int k = 0; k < 60; k++) begin
            case ($urandom % 4)
                0: op = 4'b1111;
                1: op = 4'b0000;
                2: op = OP_ID;
                default: op = 4'($urandom);
            endcase
            ir_scan(op, 2'($urandom));
            n = 1 + int'($urandom % 48);
            din = {$urandom, $urandom}; bp = {$urandom, $urandom};
            dr_scan(n, din, bp, dout);
            check("R5 R7 R8 R9 random dr scan", dout, exp_dr(op, n, din, bp));
            check("R8 R9 random bsr_sel", 64'(bsel), 64'(op == 4'b0000));
        end

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge tck);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

endmodule